// File: doc/BRIEF.md
# Dual-Lane 7:1 Parallel Serializer

This block turns a 14-bit parallel word into two serial lanes and a forwarded frame clock. A parallel clock and a bit clock at seven times its rate both arrive from outside, phase-aligned. All of the block's logic runs on the bit clock. It samples the parallel clock and treats either the rising or the falling transition as the capture moment, depending on a select input. A captured word waits in a holding register. At the start of the next seven-slot frame it moves into one shift register per lane, so each lane sends one 7-bit slice per parallel cycle.

The forwarded clock has the parallel-clock period. It is high for the first two and last two slots of each frame and low for the middle three, so a receiver can find frame boundaries. An active-high transmit enable releases every serial output to high impedance. The internal frame sequence keeps running while the outputs are released.

Top module: `lane_pair_serializer`

## Requirements
- R1: With `rise_sel` = 1, the word on `par_data` is captured at the bit-clock edge where a low-to-high transition of `clk_par` is first seen.
- R2: With `rise_sel` = 0, the word is captured at the bit-clock edge where a high-to-low transition of `clk_par` is first seen.
- R3: In slot k of a frame (k = 0..6), `lane_o[0]` carries bit k of the sent word and `lane_o[1]` carries bit 7+k, so each lane sends its least significant bit first.
- R4: `fclk_o` repeats every 7 bit-clock cycles, reading 1,1,0,0,0,1,1 over slots 0 to 6.
- R5: A word captured during one frame is sent in full during the following frame. Changes on `par_data` after the capture do not alter it.
- R6: If no selected edge of `clk_par` occurs during a frame, the next frame repeats the last captured word.
- R7: While `tx_en` is 0, `lane_o` and `fclk_o` are high impedance. Capture and framing carry on, so a word captured while disabled is sent once the outputs are enabled again.
- R8: A synchronous reset on `rst` returns to slot 0, drives both lanes low, and clears the held word, so zeros are sent until a new capture.
- R9: A capture that falls on the same bit-clock edge that starts a new frame is not sent in that frame. The frame carries the previously held word, and the new word follows one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the parallel rate |
| rst | input | 1 | Synchronous active-high reset |
| clk_par | input | 1 | Parallel clock, sampled on the bit clock |
| rise_sel | input | 1 | 1: capture on rising parallel edge; 0: on falling |
| par_data | input | 14 | Parallel word to transmit |
| tx_en | input | 1 | Active-high output enable |
| lane_o | output | 2 | Serial data lanes, high impedance when disabled |
| fclk_o | output | 1 | Forwarded frame clock, high impedance when disabled |

## Verification
Two functions can land on the same bit-clock edge: capturing a new word into the holding register and loading the holding register into the lane shifters at a frame boundary. The bench provokes this by delaying the parallel-clock rise to the last slot of a frame. The two following frames are then checked: the first must still carry the earlier word and the second the new one. In the normal runs the parallel word changes between the rising and the falling capture points. Which value arrives therefore shows which edge was used, and that later input changes left the buffered word alone.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Forwarded clock level for a given slot: low for the middle
  // (slots-1)/2 slots, high for the slots around them.
  function automatic logic fclk_level(input int unsigned slot, input int unsigned slots);
    int unsigned low_cnt;
    int unsigned head;
    low_cnt = (slots - 1) / 2;
    head    = (slots - low_cnt) / 2;
    return !((slot >= head) && (slot < head + low_cnt));
  endfunction

  // Selected-edge detection on a sampled clock.
  function automatic logic cap_event(input logic rise, input logic now, input logic prev);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction

endpackage

// File: rtl/ser_edge_capture.sv
module ser_edge_capture #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_clk,
  input  logic              rise_sel,
  input  logic [WORD_W-1:0] par_data,
  output logic              cap_evt,
  output logic [WORD_W-1:0] hold_o
);
  import ser_pkg::*;

  logic              par_q;
  logic [WORD_W-1:0] hold_q;

  assign cap_evt = cap_event(rise_sel, par_clk, par_q);
  assign hold_o  = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      par_q <= par_clk;
      if (cap_evt) hold_q <= par_data;
    end
  end

  // R1
  rise_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_sel && par_clk && !par_q) |=> (hold_q == $past(par_data)));

  // R2
  fall_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_sel && !par_clk && par_q) |=> (hold_q == $past(par_data)));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(hold_q));

endmodule

// File: rtl/ser_frame_timer.sv
module ser_frame_timer #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_o,
  output logic          frame_load,
  output logic          fclk_bit
);
  import ser_pkg::*;

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  assign slot_o     = slot_q;
  assign frame_load = (slot_q == LAST);
  assign fclk_bit   = fclk_level(32'(slot_q), SLOTS);

  always_ff @(posedge clk) begin
    if (rst)             slot_q <= '0;
    else if (frame_load) slot_q <= '0;
    else                 slot_q <= slot_q + 1'b1;
  end

  // R4
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_load |=> (slot_q == '0));

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_load |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SLOTS-1:0] load_slice,
  output logic             ser_bit
);
  logic [SLOTS-1:0] sreg;

  assign ser_bit = sreg[0];

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (load) sreg <= load_slice;
    else           sreg <= {1'b0, sreg[SLOTS-1:1]};
  end

  // R5
  slice_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sreg == $past(load_slice)));

  // R3
  lsb_first_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sreg[SLOTS-2:0] == $past(sreg[SLOTS-1:1])));

endmodule

// File: rtl/lane_pair_serializer.sv
module lane_pair_serializer #(
  parameter int unsigned LANES = 2,
  parameter int unsigned SLOTS = 7,
  localparam int unsigned WORD_W = LANES * SLOTS,
  localparam int unsigned SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              clk_par,
  input  logic              rise_sel,
  input  logic [WORD_W-1:0] par_data,
  input  logic              tx_en,
  output logic [LANES-1:0]  lane_o,
  output logic              fclk_o
);

  logic              cap_evt;
  logic [WORD_W-1:0] held_word;
  logic [SW-1:0]     slot;
  logic              frame_load;
  logic              fclk_bit;
  logic [LANES-1:0]  lane_bits;

  ser_edge_capture #(.WORD_W(WORD_W)) u_cap (
    .clk      (clk_bit),
    .rst      (rst),
    .par_clk  (clk_par),
    .rise_sel (rise_sel),
    .par_data (par_data),
    .cap_evt  (cap_evt),
    .hold_o   (held_word)
  );

  ser_frame_timer #(.SLOTS(SLOTS)) u_timer (
    .clk        (clk_bit),
    .rst        (rst),
    .slot_o     (slot),
    .frame_load (frame_load),
    .fclk_bit   (fclk_bit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ser_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk        (clk_bit),
      .rst        (rst),
      .load       (frame_load),
      .load_slice (held_word[l*SLOTS +: SLOTS]),
      .ser_bit    (lane_bits[l])
    );
    assign lane_o[l] = tx_en ? lane_bits[l] : 1'bz;
  end

  assign fclk_o = tx_en ? fclk_bit : 1'bz;

  // R8
  reset_clear_chk: assert property (@(posedge clk_bit)
    rst |=> ((lane_bits == '0) && (slot == '0)));

  // R9
  load_uses_old_chk: assert property (@(posedge clk_bit) disable iff (rst)
    (frame_load && cap_evt) |=> (lane_bits[0] == $past(held_word[0])));

endmodule

// File: tb/tb_lane_pair_serializer.sv
`timescale 1ns/1ps
module tb_lane_pair_serializer;

  logic        clk = 1'b0;
  logic        rst;
  logic        clk_par;
  logic        rise_sel;
  logic [13:0] par_data;
  logic        tx_en;
  wire  [1:0]  lane;
  wire         fclk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pullup (lane[0]);
  pullup (lane[1]);
  pullup (fclk);

  lane_pair_serializer dut (
    .clk_bit  (clk),
    .rst      (rst),
    .clk_par  (clk_par),
    .rise_sel (rise_sel),
    .par_data (par_data),
    .tx_en    (tx_en),
    .lane_o   (lane),
    .fclk_o   (fclk)
  );

  // {rise_sel, word in slots 0-2, word in slots 3-6}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 14'h1A5C, 14'h0000},
    {1'b0, 14'h0000, 14'h3FFF},
    {1'b1, 14'h2AAA, 14'h1555},
    {1'b0, 14'h0040, 14'h0080},
    {1'b1, 14'h0080, 14'h0040},
    {1'b0, 14'h3FFF, 14'h2000},
    {1'b1, 14'h0001, 14'h3FFE},
    {1'b0, 14'h1234, 14'h0F0F}
  };

  localparam logic [6:0] FCLK_EXP = 7'b1100011;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode 0: high slots 0-3; 1: constant low; 2: constant high; 3: rise only at slot 6
  task automatic run_frame(input logic sel, input logic [13:0] a, input logic [13:0] b,
                           input int mode, input logic en,
                           output logic [13:0] rx, output logic [6:0] fc);
    for (int k = 0; k < 7; k++) begin
      case (mode)
        0:       clk_par = (k < 4);
        1:       clk_par = 1'b0;
        2:       clk_par = 1'b1;
        default: clk_par = (k == 6);
      endcase
      rise_sel = sel;
      tx_en    = en;
      par_data = (k < 3) ? a : b;
      @(negedge clk);
      rx[k]     = lane[0];
      rx[7 + k] = lane[1];
      fc[k]     = fclk;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [13:0] rx;
    logic [6:0]  fc;
    logic [13:0] expw;
    logic        prev_sel;

    rst = 1'b1; clk_par = 1'b0; rise_sel = 1'b1; par_data = '0; tx_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset lanes low", 32'(lane), 32'h0);
    check("R4 reset fclk at slot0", 32'(fclk), 32'h1);
    @(posedge clk);
    #1;
    rst = 1'b0;

    // vector table: each frame sends what the previous frame captured
    expw = 14'h0000;
    prev_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      run_frame(VEC[i][28], VEC[i][27:14], VEC[i][13:0], 0, 1'b1, rx, fc);
      if (i == 0) check("R8 zeros after reset", 32'(rx), 32'(expw));
      else if (prev_sel) check("R1 R3 R5 rising capture", 32'(rx), 32'(expw));
      else check("R2 R3 R5 falling capture", 32'(rx), 32'(expw));
      check("R4 fclk pattern", 32'(fc), 32'(FCLK_EXP));
      prev_sel = VEC[i][28];
      expw = VEC[i][28] ? VEC[i][27:14] : VEC[i][13:0];
    end

    // no edges: last word then repeated
    run_frame(1'b1, 14'h0DEF, 14'h0DEF, 1, 1'b1, rx, fc);
    check("R5 last vector sent", 32'(rx), 32'(expw));
    run_frame(1'b1, 14'h0DEF, 14'h0DEF, 1, 1'b1, rx, fc);
    check("R6 repeat without capture", 32'(rx), 32'(expw));

    // disabled frame: pullups read high everywhere
    run_frame(1'b1, 14'h0000, 14'h0000, 0, 1'b0, rx, fc);
    check("R7 lanes released", 32'(rx), 32'h3FFF);
    check("R7 fclk released", 32'(fc), 32'h7F);
    run_frame(1'b1, 14'h3FFF, 14'h3FFF, 1, 1'b1, rx, fc);
    check("R7 word captured while disabled", 32'(rx), 32'h0000);

    // capture on the frame-load edge
    run_frame(1'b1, 14'h1ABC, 14'h1ABC, 1, 1'b1, rx, fc);
    check("R6 zeros repeated", 32'(rx), 32'h0000);
    run_frame(1'b1, 14'h0000, 14'h2357, 3, 1'b1, rx, fc);
    check("R9 frame before late capture", 32'(rx), 32'h0000);
    run_frame(1'b1, 14'h0111, 14'h0111, 2, 1'b1, rx, fc);
    check("R9 old word on coincident load", 32'(rx), 32'h0000);
    check("R4 fclk during late case", 32'(fc), 32'(FCLK_EXP));
    run_frame(1'b1, 14'h0111, 14'h0111, 1, 1'b1, rx, fc);
    check("R9 new word one frame later", 32'(rx), 32'h2357);

    // mid-run reset clears held word
    rst = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    check("R8 mid-run lanes low", 32'(lane), 32'h0);
    check("R8 mid-run fclk slot0", 32'(fclk), 32'h1);
    @(posedge clk);
    #1;
    rst = 1'b0;
    run_frame(1'b1, 14'h0000, 14'h0000, 1, 1'b1, rx, fc);
    check("R8 shifters cleared", 32'(rx), 32'h0000);
    run_frame(1'b1, 14'h0000, 14'h0000, 1, 1'b1, rx, fc);
    check("R8 held word cleared", 32'(rx), 32'h0000);

    finish_run();
  end

endmodule